// File: doc/BRIEF.md
# Multi-Channel Phase-Accumulator PWM Controller

This block drives a set of pulse-width-modulated outputs, one per channel, each programmed through a single 32-bit control word on a simple register port. Rather than counting a period, every channel runs a 16-bit phase accumulator that gains a programmable step on each clock. The output frequency is therefore the clock frequency times the step divided by 65536. The duty cycle comes from an 8-bit threshold compared against the top byte of the accumulator. A larger threshold gives a shorter high time, roughly 255 minus 255 times the wanted duty fraction.

Software writes new step and threshold values into staged fields. They reach the running waveform only when the update-request bit is set with them. While a channel runs, they are taken on the clock where its accumulator wraps, so a PWM cycle is never cut short. While a channel is stopped, they are taken as soon as they are written. The channel count is a parameter. Channel k decodes at byte address k·0x400, with its control word at offset 0.

Top module: `pwm_phase_ctrl`

## Requirements
- R1: After reset every control word reads 0, every PWM output is low and the read data output is 0.
- R2: Control word layout: bit 31 = run enable, bit 30 = update request, bits [23:8] = 16-bit phase step, bits [7:0] = on-time threshold; bits [29:24] read as 0. A read returns the staged fields on `rd_data` one clock after `rd_en` is sampled, and `rd_data` holds between reads.
- R3: Channel k responds only at byte address k·0x400 (offset 0). A write to any other address changes no channel. A read of any other address, including a channel index at or above the channel count, returns 0.
- R4: While a channel is disabled, its accumulator is held at 0 and its output is low. A write with bit 30 set to a disabled channel loads that write's step and threshold into the running settings at once, and bit 30 reads back 0.
- R5: While enabled, the accumulator starts from 0 and gains the running step on every clock, modulo 65536.
- R6: While enabled, the output is high exactly when accumulator bits [15:8] are greater than or equal to the running threshold. A threshold of 0 gives a constant high, and a threshold above the largest reachable top byte gives a constant low.
- R7: A write with bit 30 set to an enabled channel leaves the running step and threshold unchanged until the clock on which the accumulator wraps. On that clock the staged values are loaded and bit 30 clears.
- R8: Staged values written with bit 30 clear never reach the running waveform of an enabled channel.
- R9: A written step above 0x8002 is stored as 0x8002. Steps up to 0x8002 are stored unchanged.
- R10: Channels are independent. Each runs its own waveform, and writing one channel does not affect another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| rd_en | input | 1 | Read strobe for the word at `addr` |
| addr | input | ADDR_W | Byte address |
| wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, registered |
| pwm_out | output | NUM_CH | One PWM output per channel |

## Verification
A write lands on the clock edge that samples `wr_en`. Read data appears one edge after `rd_en` is sampled. For this reason, every expected read value is queued by the driver and compared by a monitor at the falling edge that follows that sampling edge. Waveform checks measure time in rising edges since the enabling write: at that many edges the top byte of the accumulator equals the edge count times the step. The checks sample exact edge numbers around the threshold crossing and the wrap. Duty checks count high cycles over a whole number of periods, so the phase at which counting starts does not matter.

// File: rtl/pwm_phase_pkg.sv
package pwm_phase_pkg;

    localparam int ACC_W       = 16;
    localparam int THR_W       = 8;
    localparam int WORD_W      = 32;
    localparam int STRIDE_LOG2 = 10;
    localparam int EN_POS      = 31;
    localparam int UPD_POS     = 30;
    localparam int STEP_LSB    = 8;
    localparam logic [ACC_W-1:0] STEP_MAX = 16'h8002;

    typedef struct packed {
        logic             en;
        logic             upd;
        logic [ACC_W-1:0] step;
        logic [THR_W-1:0] thr;
    } chan_cfg_t;

    typedef struct packed {
        chan_cfg_t        stg;
        logic [ACC_W-1:0] run_step;
        logic [THR_W-1:0] run_thr;
        logic [ACC_W-1:0] acc;
    } chan_state_t;

    function automatic logic [WORD_W-1:0] cfg_to_word(chan_cfg_t c);
        return {c.en, c.upd, 6'b0, c.step, c.thr};
    endfunction

endpackage

// File: rtl/pwm_addr_dec.sv
module pwm_addr_dec #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ch_sel,
    output logic              hit
);
    import pwm_phase_pkg::*;

    localparam int CH_FW = ADDR_W - STRIDE_LOG2;

    logic off_zero;

    always_comb begin
        off_zero = (addr[STRIDE_LOG2-1:0] == '0);
    end

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
            always_comb begin
                ch_sel[g] = off_zero && (addr[ADDR_W-1:STRIDE_LOG2] == CH_FW'(g));
            end
        end
    endgenerate

    always_comb begin
        hit = |ch_sel;
    end

endmodule

// File: rtl/pwm_chan.sv
module pwm_chan (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             wr_stb,
    input  logic [pwm_phase_pkg::WORD_W-1:0] wdata,
    output pwm_phase_pkg::chan_cfg_t         cfg_o,
    output logic                             pwm_o
);
    import pwm_phase_pkg::*;

    chan_state_t      st_d, st_q;
    logic [ACC_W:0]   sum_ext;
    logic             wrap;
    logic [ACC_W-1:0] wr_step;
    logic             unused_rsvd;

    always_comb begin
        unused_rsvd = ^wdata[29:24];
        wr_step     = wdata[STEP_LSB +: ACC_W];
        if (wr_step > STEP_MAX) begin
            wr_step = STEP_MAX;
        end
        sum_ext = {1'b0, st_q.acc} + {1'b0, st_q.run_step};
        wrap    = st_q.stg.en && sum_ext[ACC_W];

        st_d = st_q;
        // accumulator runs only while enabled
        st_d.acc = st_q.stg.en ? sum_ext[ACC_W-1:0] : '0;

        // boundary load of a pending update
        if (wrap && st_q.stg.upd) begin
            st_d.run_step = st_q.stg.step;
            st_d.run_thr  = st_q.stg.thr;
            st_d.stg.upd  = 1'b0;
        end

        if (wr_stb) begin
            st_d.stg.en   = wdata[EN_POS];
            st_d.stg.upd  = wdata[UPD_POS];
            st_d.stg.step = wr_step;
            st_d.stg.thr  = wdata[THR_W-1:0];
            // stopped channel: no cycle to protect, apply at once
            if (!st_q.stg.en && wdata[UPD_POS]) begin
                st_d.run_step = wr_step;
                st_d.run_thr  = wdata[THR_W-1:0];
                st_d.stg.upd  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_o = st_q.stg;
        pwm_o = st_q.stg.en && (st_q.acc[ACC_W-1 -: THR_W] >= st_q.run_thr);
    end

    p_idle_acc_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.stg.en |=> (st_q.acc == '0));

    p_run_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stg.en && !sum_ext[ACC_W]) |=> ($stable(st_q.run_step) && $stable(st_q.run_thr)));

    p_upd_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stg.en && sum_ext[ACC_W] && st_q.stg.upd && !wr_stb) |=> !st_q.stg.upd);

    p_step_limit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> (st_q.stg.step <= STEP_MAX));

endmodule

// File: rtl/pwm_phase_ctrl.sv
module pwm_phase_ctrl #(
    parameter int NUM_CH = 2,
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rd_data,
    output logic [NUM_CH-1:0] pwm_out
);
    import pwm_phase_pkg::*;

    typedef struct packed {
        logic [WORD_W-1:0] rdat;
    } rd_state_t;

    logic [NUM_CH-1:0] ch_sel;
    logic              hit;
    logic [WORD_W-1:0] cfg_word [NUM_CH];
    logic [WORD_W-1:0] rd_mux;
    rd_state_t         rs_d, rs_q;

    pwm_addr_dec #(
        .NUM_CH (NUM_CH),
        .ADDR_W (ADDR_W)
    ) u_dec (
        .addr   (addr),
        .ch_sel (ch_sel),
        .hit    (hit)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            chan_cfg_t cfg_g;
            pwm_chan u_chan (
                .clk    (clk),
                .rst_n  (rst_n),
                .wr_stb (wr_en && ch_sel[g]),
                .wdata  (wdata),
                .cfg_o  (cfg_g),
                .pwm_o  (pwm_out[g])
            );
            always_comb begin
                cfg_word[g] = cfg_to_word(cfg_g);
            end
        end
    endgenerate

    always_comb begin
        rd_mux = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (ch_sel[k]) begin
                rd_mux = rd_mux | cfg_word[k];
            end
        end
        rs_d = rs_q;
        if (rd_en) begin
            rs_d.rdat = hit ? rd_mux : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rs_q <= '0;
        end else begin
            rs_q <= rs_d;
        end
    end

    always_comb begin
        rd_data = rs_q.rdat;
    end

    p_miss_reads_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !hit) |=> (rd_data == '0));

    p_hold_between_reads_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

endmodule

// File: tb/tb_pwm_phase_ctrl.sv
module tb_pwm_phase_ctrl;

    localparam int NUM_CH = 2;
    localparam int ADDR_W = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0]       wdata = '0;
    logic [31:0]       rd_data;
    logic [NUM_CH-1:0] pwm_out;

    int  n_chk = 0;
    int  n_fail = 0;
    int  cyc = 0;
    bit  done = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } rd_item_t;

    rd_item_t sb_q[$];
    rd_item_t cur;
    logic     rd_seen = 1'b0;

    pwm_phase_ctrl #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wdata   (wdata),
        .rd_data (rd_data),
        .pwm_out (pwm_out)
    );

    // 4 ns period
    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc     <= cyc + 1;
        rd_seen <= rd_en;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: read data is due one edge after rd_en is sampled
    always @(negedge clk) begin
        if (rd_seen) begin
            if (sb_q.size() == 0) begin
                check(1'b0, "scoreboard empty", rd_data, 32'h0);
            end else begin
                cur = sb_q.pop_front();
                check(rd_data === cur.exp, cur.tag, rd_data, cur.exp);
            end
        end
    end

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
        rd_item_t it;
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        it.exp = exp; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic count_high(input int n, output int c0, output int c1);
        c0 = 0; c1 = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            c0 += int'(pwm_out[0]);
            c1 += int'(pwm_out[1]);
        end
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
        finish_run();
    end

    initial begin
        int c0, c1, t0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check(pwm_out == '0, "R1 pwm low in reset", 32'(pwm_out), 0);
        check(rd_data == '0, "R1 read data zero", rd_data, 0);
        rst_n = 1'b1;
        bus_read(12'h000, 32'h0, "R1 ch0 word");
        bus_read(12'h400, 32'h0, "R1 ch1 word");

        // R2 layout, reserved bits read zero
        bus_write(12'h000, 32'h3F40_0080);
        bus_read(12'h000, 32'h0040_0080, "R2 reserved bits zero");
        // R9 step saturation
        bus_write(12'h000, 32'h00FF_FF00);
        bus_read(12'h000, 32'h0080_0200, "R9 step clamp");
        bus_write(12'h000, 32'h0080_0200);
        bus_read(12'h000, 32'h0080_0200, "R9 limit kept");
        bus_write(12'h000, 32'h0080_0100);
        bus_read(12'h000, 32'h0080_0100, "R9 below limit kept");

        // R3 decode
        bus_write(12'h004, 32'h8040_0000);
        bus_read(12'h000, 32'h0080_0100, "R3 offset write ignored");
        bus_read(12'h004, 32'h0, "R3 offset read zero");
        bus_write(12'h800, 32'h8040_0000);
        bus_read(12'h800, 32'h0, "R3 out-of-range read zero");
        bus_read(12'h400, 32'h0, "R3 out-of-range write ignored");

        // R4 disabled update applies at once, output low
        bus_write(12'h000, 32'h4040_0080);
        bus_read(12'h000, 32'h0040_0080, "R4 update bit cleared");
        count_high(8, c0, c1);
        check(c0 == 0, "R4 disabled output low", c0, 0);

        // R6 duty from threshold (step 0x4000, period 4)
        bus_write(12'h000, 32'h8040_0080);
        count_high(16, c0, c1);
        check(c0 == 8, "R6 half duty", c0, 8);
        // R8 staged without update not applied
        bus_write(12'h000, 32'h8040_00C0);
        count_high(16, c0, c1);
        check(c0 == 8, "R8 staged ignored", c0, 8);
        bus_read(12'h000, 32'h8040_00C0, "R8 staged readback");
        // R7 update at boundary
        bus_write(12'h000, 32'hC040_00C0);
        repeat (8) @(negedge clk);
        count_high(16, c0, c1);
        check(c0 == 4, "R7 quarter duty after update", c0, 4);
        bus_write(12'h000, 32'hC040_0000);
        repeat (8) @(negedge clk);
        count_high(16, c0, c1);
        check(c0 == 16, "R6 zero threshold always high", c0, 16);
        bus_write(12'h000, 32'hC040_00FF);
        repeat (8) @(negedge clk);
        count_high(16, c0, c1);
        check(c0 == 0, "R6 unreachable threshold low", c0, 0);
        // R5 step 0x8000, period 2
        bus_write(12'h000, 32'hC080_0080);
        repeat (8) @(negedge clk);
        count_high(16, c0, c1);
        check(c0 == 8, "R5 step 0x8000 duty", c0, 8);

        // R10 channel independence
        bus_write(12'h000, 32'hC040_0080);
        bus_write(12'h400, 32'hC040_0040);
        repeat (8) @(negedge clk);
        count_high(16, c0, c1);
        check(c0 == 8, "R10 ch0 duty", c0, 8);
        check(c1 == 12, "R10 ch1 duty", c1, 12);
        bus_read(12'h400, 32'h8040_0040, "R10 ch1 word");

        // R5/R7 exact timing with slow step 0x0100
        bus_write(12'h000, 32'h0000_0000);
        bus_write(12'h000, 32'hC001_0080);
        t0 = cyc;
        bus_write(12'h000, 32'hC001_0000);
        bus_read(12'h000, 32'hC001_0000, "R7 update pending");
        wait_until(t0 + 120);
        check(pwm_out[0] == 1'b0, "R7 old threshold before wrap", 32'(pwm_out[0]), 0);
        wait_until(t0 + 127);
        check(pwm_out[0] == 1'b0, "R5 below threshold at 127", 32'(pwm_out[0]), 0);
        wait_until(t0 + 128);
        check(pwm_out[0] == 1'b1, "R5 reaches threshold at 128", 32'(pwm_out[0]), 1);
        wait_until(t0 + 257);
        check(pwm_out[0] == 1'b1, "R7 new threshold after wrap", 32'(pwm_out[0]), 1);
        bus_read(12'h000, 32'h8001_0000, "R7 update bit cleared");

        repeat (4) @(negedge clk);
        check(sb_q.size() == 0, "R2 all reads answered", sb_q.size(), 0);
        finish_run();
    end

endmodule